// File: doc/BRIEF.md
# Sample-Rate Converter Timing Select Divider

This block produces the timing pulse that paces one side (input or output) of each sample-rate converter channel. Every channel picks one source from three external audio clock ticks, the two baud-rate generator ticks, or a serial-port word-select strobe. A divided source then goes through a counter whose ratio comes from a fixed table of 30 steps. A word-select strobe is passed on without division.

Software programs two channels at a time through one 32-bit write. The even channel of a pair takes the low half-word and the odd channel takes the high half-word. All source inputs are single-cycle tick pulses that are already synchronous to the block clock. The output is one pulse per channel, one cycle wide. None of the signals is a stream: there is no valid/ready handshake and no back-pressure. A tick that arrives is counted in the cycle it is present, or else it is lost.

Top module: `src_timing_divider`

## Requirements
- R1: In each 16-bit channel field, bits [11:8] hold the source code and bits [4:0] hold the ratio index. Bits [7:5] and [15:12] have no effect on behaviour.
- R2: A write to pair register `cfg_addr` loads channel 2*cfg_addr from `cfg_wdata[15:0]` and channel 2*cfg_addr+1 from `cfg_wdata[31:16]`. Channels of other pairs are untouched.
- R3: Source codes 0, 1 and 2 select external ticks 0, 1 and 2. Codes 3 and 4 select generator ticks 0 and 1. A code 6+k selects word-select strobe k. Code 5, and any strobe number that does not exist, give no pulse.
- R4: Indices 0 to 3 divide by 2, 4, 6 and 8. Each later index multiplies the ratio alternately by 3/2 and by 4/3 (12, 16, 24, 32, ...).
- R5: Index 28 divides by 49152. Index 29 divides by 98304, so 65536 is skipped.
- R6: A divided channel raises its pulse for exactly one cycle, in the cycle after the tick that completes a full ratio of counted ticks.
- R7: When a word-select strobe is selected, every strobe tick gives a pulse one cycle later and the index has no effect.
- R8: While `ws_share` is 1, strobe numbers 1, 2 and 9 are taken from strobe 0, strobe 4 from strobe 3, and strobe 8 from strobe 7. The rest map to themselves.
- R9: Indices 30 and 31 are reserved. The pulse stays low while one of them is selected.
- R10: A divided source code c is active only while `div_en[c+1]` is 1. While that bit is 0, the channel's counter is held at zero and no pulse is given.
- R11: A write to a pair restarts the counters of both of its channels. The first pulse then comes a full ratio of ticks after the write cycle.
- R12: After reset every field is zero and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one pair register |
| cfg_addr | input | ADDR_W | Pair register number |
| cfg_wdata | input | 32 | Two channel fields: even channel low, odd channel high |
| ws_share | input | 1 | Shared-pin strobe routing enable |
| div_en | input | 6 | Enable per divided source; bit c+1 for source code c |
| ext_tick | input | 3 | External audio clock ticks (codes 0 to 2) |
| brg_tick | input | 2 | Baud-rate generator ticks (codes 3 and 4) |
| ws_tick | input | NUM_WS | Word-select strobe ticks per serial port |
| tsel_pulse | output | NUM_CH | Timing pulse per converter channel |

## Verification
The assertions check on every cycle that a pulse always follows a tick, that a divided pulse is never two cycles wide, and that the counter stays below the ratio of its index. They also check that reserved indices, disabled sources and pair writes force the pulse low, and that a write places each half-word in the right channel. The ratio values themselves need the bench's scenarios, because only an observed spacing between pulses shows them, and the index 28 and 29 runs take almost a hundred thousand cycles. The same holds for strobe routing under pin sharing, the rejection of code 5, and the fact that stray field bits have no effect. The bench also compares every output cycle of a randomized run against its own model.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  localparam int SRC_W       = 4;
  localparam int IDX_W       = 5;
  localparam int RATIO_W     = 17;
  localparam int NUM_DIV_SRC = 5;
  localparam int EN_W        = NUM_DIV_SRC + 1;
  localparam int WS_BASE     = 6;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [IDX_W-1:0] idx;
  } tsel_cfg_t;

  // Division ratio for a table index; 0 marks a reserved index.
  function automatic logic [RATIO_W-1:0] ratio_of(input logic [IDX_W-1:0] idx);
    int n;
    n = int'(idx);
    if (n == 0)  return RATIO_W'(2);
    if (n == 29) return RATIO_W'(98304);
    if (n >= 30) return '0;
    if ((n % 2) == 1) return RATIO_W'(1) << ((n + 3) / 2);
    return RATIO_W'(6) << ((n - 2) / 2);
  endfunction

  // Strobe routing when serial ports share their pins.
  function automatic int ws_route(input int port, input logic share);
    if (!share) return port;
    case (port)
      1, 2, 9: return 0;
      4:       return 3;
      8:       return 7;
      default: return port;
    endcase
  endfunction

endpackage

// File: rtl/tsel_cfg_regs.sv
module tsel_cfg_regs
  import tsel_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output tsel_cfg_t         cfg_o [NUM_CH],
  output logic [NUM_CH-1:0] restart_o
);

  logic [31:0] unused_bits;
  assign unused_bits = wdata_i & 32'hF0E0_F0E0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int BASE = (c % 2) * 16;

    assign restart_o[c] = we_i && (addr_i == ADDR_W'(c / 2));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_o[c] <= '0;
      end else if (restart_o[c]) begin
        cfg_o[c].src <= wdata_i[BASE+11:BASE+8];
        cfg_o[c].idx <= wdata_i[BASE+4:BASE];
      end
    end

    // R2
    half_field_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o[c] |=> (cfg_o[c].src == $past(wdata_i[BASE+11:BASE+8]))
                    && (cfg_o[c].idx == $past(wdata_i[BASE+4:BASE])));
  end

endmodule

// File: rtl/tsel_src_sel.sv
module tsel_src_sel
  import tsel_pkg::*;
#(
  parameter int NUM_WS = 10
) (
  input  tsel_cfg_t         cfg_i,
  input  logic              share_i,
  input  logic [EN_W-1:0]   div_en_i,
  input  logic [2:0]        ext_tick_i,
  input  logic [1:0]        brg_tick_i,
  input  logic [NUM_WS-1:0] ws_tick_i,
  output logic              tick_o,
  output logic              ws_mode_o,
  output logic              active_o
);

  logic [NUM_DIV_SRC-1:0] div_tick;
  int route;

  assign div_tick = {brg_tick_i, ext_tick_i};

  always_comb begin
    tick_o    = 1'b0;
    ws_mode_o = 1'b0;
    active_o  = 1'b0;
    route     = -1;
    if (cfg_i.src < SRC_W'(NUM_DIV_SRC)) begin
      active_o = div_en_i[cfg_i.src[2:0] + 3'd1];
      tick_o   = div_tick[cfg_i.src[2:0]];
    end else if (cfg_i.src >= SRC_W'(WS_BASE)) begin
      route = ws_route(int'(cfg_i.src) - WS_BASE, share_i);
      for (int p = 0; p < NUM_WS; p++) begin
        if (route == p) begin
          ws_mode_o = 1'b1;
          active_o  = 1'b1;
          tick_o    = ws_tick_i[p];
        end
      end
    end
  end

endmodule

// File: rtl/tsel_divider.sv
module tsel_divider
  import tsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             tick_i,
  input  logic             ws_mode_i,
  input  logic             active_i,
  output logic             pulse_o
);

  logic [RATIO_W-1:0] ratio;
  logic [RATIO_W-1:0] cnt_q;
  logic               reserved;

  assign ratio    = ratio_of(idx_i);
  assign reserved = (idx_i[IDX_W-1:1] == 4'b1111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (restart_i || reserved || !active_i) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (ws_mode_i) begin
      cnt_q   <= '0;
      pulse_o <= tick_i;
    end else if (tick_i) begin
      if (cnt_q == ratio - RATIO_W'(1)) begin
        cnt_q   <= '0;
        pulse_o <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + RATIO_W'(1);
        pulse_o <= 1'b0;
      end
    end else begin
      pulse_o <= 1'b0;
    end
  end

  // R6
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(tick_i));

  // R6
  divided_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && !ws_mode_i && !restart_i) |=> !pulse_o);

  // R4
  count_below_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reserved |-> (cnt_q < ratio));

  // R9
  reserved_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reserved |=> !pulse_o);

  // R10
  disabled_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (!pulse_o && cnt_q == '0));

  // R11
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (!pulse_o && cnt_q == '0));

endmodule

// File: rtl/src_timing_divider.sv
module src_timing_divider
  import tsel_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_WS  = 10,
  localparam int NUM_PAIRS = NUM_CH / 2,
  localparam int ADDR_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              ws_share,
  input  logic [5:0]        div_en,
  input  logic [2:0]        ext_tick,
  input  logic [1:0]        brg_tick,
  input  logic [NUM_WS-1:0] ws_tick,
  output logic [NUM_CH-1:0] tsel_pulse
);

  tsel_cfg_t         cfg [NUM_CH];
  logic [NUM_CH-1:0] restart;

  tsel_cfg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (cfg_we),
    .addr_i    (cfg_addr),
    .wdata_i   (cfg_wdata),
    .cfg_o     (cfg),
    .restart_o (restart)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic tick;
    logic ws_mode;
    logic active;

    tsel_src_sel #(.NUM_WS(NUM_WS)) u_sel (
      .cfg_i      (cfg[c]),
      .share_i    (ws_share),
      .div_en_i   (div_en),
      .ext_tick_i (ext_tick),
      .brg_tick_i (brg_tick),
      .ws_tick_i  (ws_tick),
      .tick_o     (tick),
      .ws_mode_o  (ws_mode),
      .active_o   (active)
    );

    tsel_divider u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart[c]),
      .idx_i     (cfg[c].idx),
      .tick_i    (tick),
      .ws_mode_i (ws_mode),
      .active_i  (active),
      .pulse_o   (tsel_pulse[c])
    );
  end

endmodule

// File: tb/src_timing_divider_bench.sv
module src_timing_divider_bench;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int NWS   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  logic           cfg_we = 1'b0;
  logic [0:0]     cfg_addr = '0;
  logic [31:0]    cfg_wdata = '0;
  logic           ws_share = 1'b0;
  logic [5:0]     div_en = '0;
  logic [2:0]     ext_tick = '0;
  logic [1:0]     brg_tick = '0;
  logic [NWS-1:0] ws_tick = '0;
  logic [NCH-1:0] tsel_pulse;

  src_timing_divider #(.NUM_CH(NCH), .NUM_WS(NWS)) u_src_timing_divider (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ws_share(ws_share), .div_en(div_en),
    .ext_tick(ext_tick), .brg_tick(brg_tick), .ws_tick(ws_tick),
    .tsel_pulse(tsel_pulse)
  );

  int checks = 0;
  int fails = 0;
  string tag = "R12";

  logic           b_we = 1'b0;
  logic [0:0]     b_addr = '0;
  logic [31:0]    b_wdata = '0;
  logic           b_share = 1'b0;
  logic [5:0]     b_en = '0;
  logic [2:0]     b_ext = '0;
  logic [1:0]     b_brg = '0;
  logic [NWS-1:0] b_ws = '0;

  logic [15:0]    m_cfg [NCH];
  int             m_cnt [NCH];
  logic [NCH-1:0] m_exp = '0;
  int             pc [NCH];
  logic [NCH-1:0] smp;

  function automatic int exp_ratio(input int idx);
    int r;
    if (idx == 29) return 2 * exp_ratio(28);
    if (idx <= 3) return 2 * (idx + 1);
    r = 8;
    for (int k = 4; k <= idx; k++) r = (k % 2 == 0) ? (r * 3) / 2 : (r * 4) / 3;
    return r;
  endfunction

  function automatic int route(input int port, input bit sh);
    if (!sh) return port;
    if (port == 1 || port == 2 || port == 9) return 0;
    if (port == 4) return 3;
    if (port == 8) return 7;
    return port;
  endfunction

  task automatic check_eq(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic clear_pc();
    for (int ch = 0; ch < NCH; ch++) pc[ch] = 0;
  endtask

  task automatic step();
    @(negedge clk);
    smp = tsel_pulse;
    checks++;
    if (tsel_pulse !== m_exp) begin
      fails++;
      $display("FAIL %s: pulse actual %b expected %b", tag, tsel_pulse, m_exp);
    end
    for (int ch = 0; ch < NCH; ch++) if (tsel_pulse[ch]) pc[ch]++;
    cfg_we = b_we; cfg_addr = b_addr; cfg_wdata = b_wdata; ws_share = b_share;
    div_en = b_en; ext_tick = b_ext; brg_tick = b_brg; ws_tick = b_ws;
    for (int ch = 0; ch < NCH; ch++) begin
      int src, idx, r;
      logic t, nexp;
      nexp = 1'b0;
      if (b_we && int'(b_addr) == ch / 2) begin
        m_cfg[ch] = ((ch % 2) ? b_wdata[31:16] : b_wdata[15:0]) & 16'h0F1F;
        m_cnt[ch] = 0;
      end else begin
        src = int'(m_cfg[ch][11:8]);
        idx = int'(m_cfg[ch][4:0]);
        if (idx >= 30) m_cnt[ch] = 0;
        else if (src >= 6) begin
          r = route(src - 6, b_share);
          m_cnt[ch] = 0;
          if (r < NWS) nexp = b_ws[r];
        end else if (src <= 4 && b_en[src + 1]) begin
          t = (src < 3) ? b_ext[src] : b_brg[src - 3];
          if (t) begin
            if (m_cnt[ch] + 1 == exp_ratio(idx)) begin
              nexp = 1'b1;
              m_cnt[ch] = 0;
            end else m_cnt[ch]++;
          end
        end else m_cnt[ch] = 0;
      end
      m_exp[ch] = nexp;
    end
    b_we = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_pair(input int a, input logic [31:0] d);
    b_we = 1'b1; b_addr = 1'(a); b_wdata = d;
    step();
    clear_pc();
  endtask

  task automatic measure_period(input int idx);
    int first, second;
    first = -1; second = -1;
    write_pair(0, {16'h0000, 16'h0100 | 16'(idx)});
    for (int j = 1; j <= 2 * exp_ratio(idx) + 4; j++) begin
      step();
      if (smp[0]) begin
        if (first < 0) first = j;
        else if (second < 0) second = j;
      end
    end
    check_eq("R4 first pulse", first, exp_ratio(idx) + 1);
    check_eq("R4 period", second - first, exp_ratio(idx));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int ch = 0; ch < NCH; ch++) begin m_cfg[ch] = '0; m_cnt[ch] = 0; pc[ch] = 0; end
    repeat (3) @(negedge clk);
    check_eq("R12 reset pulse", int'(tsel_pulse), 0);
    rst_n = 1'b1;
    step();
    check_eq("R12 after reset", int'(smp), 0);

    // R1: stray bits in both halves; R10: channel 1 source disabled
    tag = "R1"; b_en = 6'b000100; b_ext = 3'b010;
    write_pair(0, {16'hF0E0, 16'hF1E1});
    run(41);
    check_eq("R1 stray bits ignored", pc[0], 10);
    check_eq("R10 clock A disabled", pc[1], 0);

    // R4: ratio table
    tag = "R4";
    for (int i = 0; i <= 12; i++) measure_period(i);

    // R5: long ratios
    tag = "R5";
    write_pair(0, {16'h011C, 16'h011D});
    run(98306);
    check_eq("R5 index 29 pulses", pc[0], 1);
    check_eq("R5 index 28 pulses", pc[1], 2);

    // R11: rewrite restarts
    begin
      int first;
      first = -1;
      tag = "R11";
      write_pair(0, {16'h0000, 16'h0103});
      run(5);
      write_pair(0, {16'h0000, 16'h0103});
      for (int j = 1; j <= 12; j++) begin
        step();
        if (smp[0] && first < 0) first = j;
      end
      check_eq("R11 restart delay", first, 9);
    end

    // R9: reserved indices
    tag = "R9";
    write_pair(0, {16'h011E, 16'h011F});
    run(40);
    check_eq("R9 index 30", pc[0], 0);
    check_eq("R9 index 31", pc[1], 0);

    // R10: enable bit position c+1
    tag = "R10"; b_ext = 3'b000; b_brg = 2'b11; b_en = 6'b000000;
    write_pair(0, {16'h0400, 16'h0300});
    run(20);
    check_eq("R10 all disabled", pc[0] + pc[1], 0);
    b_en = 6'b001000; clear_pc(); run(20);
    check_eq("R10 wrong bit", pc[0], 0);
    b_en = 6'b011000; clear_pc(); run(21);
    check_eq("R10 code 3 enabled", pc[0], 10);
    check_eq("R10 code 4 still off", pc[1], 0);

    // R3: code 5 is silent
    tag = "R3"; b_en = 6'b111111; b_ext = 3'b111; b_brg = 2'b11; b_ws = '1;
    write_pair(0, {16'h0500, 16'h0500});
    run(20);
    check_eq("R3 code 5", pc[0] + pc[1], 0);
    b_ws = '0;

    // R2: odd channel takes the high half
    tag = "R2"; b_en = 6'b001010; b_ext = 3'b100; b_brg = 2'b00;
    write_pair(1, {16'h0200, 16'h0000});
    run(21);
    check_eq("R2 odd channel clock C", pc[3], 10);
    check_eq("R2 even channel clock A idle", pc[2], 0);
    check_eq("R2 other pair untouched", pc[0], 0);

    // R7: strobe passes undivided
    tag = "R7"; b_ext = 3'b000; b_share = 1'b0;
    write_pair(1, {16'h0F00, 16'h0913});
    b_ws = 10'(1 << 3); step(); b_ws = '0; run(3);
    check_eq("R7 strobe 3", pc[2], 1);
    check_eq("R7 strobe 9 idle", pc[3], 0);

    // R8: shared pins
    tag = "R8"; b_share = 1'b1; clear_pc();
    b_ws = 10'(1 << 0); step(); b_ws = '0; run(3);
    check_eq("R8 port 9 from strobe 0", pc[3], 1);
    b_ws = 10'(1 << 9); step(); b_ws = '0; run(3);
    check_eq("R8 strobe 9 not used", pc[3], 1);
    write_pair(1, {16'h0F00, 16'h0A00});
    b_ws = 10'(1 << 3); step(); b_ws = '0; run(3);
    check_eq("R8 port 4 from strobe 3", pc[2], 1);

    // R6: randomized run against the model
    tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      b_ext = 3'($urandom); b_brg = 2'($urandom); b_ws = NWS'($urandom);
      b_share = 1'($urandom);
      if (i % 40 == 0) b_en = 6'($urandom);
      if ($urandom % 25 == 0) begin
        logic [31:0] w;
        int k;
        w = $urandom;
        k = $urandom % 14; w[4:0]   = (k < 12) ? 5'(k) : 5'(30 + (k % 2));
        k = $urandom % 14; w[20:16] = (k < 12) ? 5'(k) : 5'(30 + (k % 2));
        b_we = 1'b1; b_addr = 1'($urandom); b_wdata = w;
      end
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule